// File: doc/BRIEF.md
# Accumulator-to-Intermediate Saturation Stage

This stage sits after a three-channel multiply-accumulate unit. It takes three signed 32-bit accumulator results and clamps each one into a 16-bit intermediate register. A mode bit picks the clamp window. With the mode bit clear the window is the full signed 16-bit range. With it set the window starts at zero, so negative results become zero.

Each channel that had to be clamped raises its own bit in a 32-bit status word. That word arrives from the preceding stage and is carried forward, so every bit set upstream is kept. The first two channels also raise the summary error bit. The third channel does not.

All outputs are registered together. They update one clock after a valid strobe and hold their value between strobes. A build parameter selects a variant that performs the same clamping but passes the status word through without change.

Top module: `acc_ir_sat`

## Requirements
- R1: With `lm_i`=0, each channel output equals its accumulator clamped to -32768..32767, written as 16-bit two's complement. In-range values pass through exactly.
- R2: With `lm_i`=1, each channel output equals its accumulator clamped to 0..32767. Any negative accumulator yields 0.
- R3: When channel 0 is clamped, in either direction, bit 24 and bit 31 of `flag_o` are set.
- R4: When channel 1 is clamped, in either direction, bit 23 and bit 31 of `flag_o` are set.
- R5: When channel 2 is clamped, bit 22 of `flag_o` is set. Bit 31 is not set by channel 2.
- R6: `flag_o` is `flag_i` OR-ed with the new bits. Every bit set in `flag_i` stays set, and no other bit changes.
- R7: An accumulator exactly equal to the active upper or lower bound passes through unchanged and sets no flag bit.
- R8: `valid_o` equals `valid_i` delayed by one clock. All three channels and the flag word are updated in that same cycle.
- R9: While `valid_i` is low, `ir*_o` and `flag_o` keep their last values.
- R10: While `rst_ni` is low, all outputs are zero.
- R11: With parameter `UPDATE_FLAGS`=0, clamping is the same as in R1 and R2, and `flag_o` is the registered `flag_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input data valid strobe |
| lm_i | input | 1 | Limit mode: 0 = signed window, 1 = non-negative window |
| acc0_i | input | 32 | Channel 0 accumulator, signed |
| acc1_i | input | 32 | Channel 1 accumulator, signed |
| acc2_i | input | 32 | Channel 2 accumulator, signed |
| flag_i | input | 32 | Incoming status word |
| valid_o | output | 1 | Output valid, one clock after `valid_i` |
| ir0_o | output | 16 | Channel 0 clamped value |
| ir1_o | output | 16 | Channel 1 clamped value |
| ir2_o | output | 16 | Channel 2 clamped value |
| flag_o | output | 32 | Updated status word |

## Verification
The assertions assume the following about the inputs:
- Every input is known whenever `valid_i` is high.
- The status-word properties compare `flag_o` against the `flag_i` sampled at the strobe. They therefore rely on `flag_i` being meaningful only at strobe cycles.

The stimulus keeps within these assumptions. It drives all inputs to known values on the falling edge, including during idle cycles. Idle cycles still carry random accumulators, mode and flag values, so that holding (R9) is tested against live, changing inputs.

// File: rtl/acc_ir_sat_pkg.sv
package acc_ir_sat_pkg;
  localparam int unsigned ACC_W    = 32;
  localparam int unsigned IR_W     = 16;
  localparam int unsigned FLAG_W   = 32;
  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned HIT_BASE = 24;  // channel k flags bit HIT_BASE-k
  localparam int unsigned SUM_BIT  = 31;
  localparam int unsigned SUM_CH   = 2;   // channels below this raise SUM_BIT

  function automatic logic [FLAG_W-1:0] ch_mask(int unsigned ch);
    logic [FLAG_W-1:0] m;
    m = '0;
    m[HIT_BASE - ch] = 1'b1;
    if (ch < SUM_CH) m[SUM_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/acc_ir_sat_lane.sv
module acc_ir_sat_lane
  import acc_ir_sat_pkg::*;
#(
  parameter int unsigned A_W = ACC_W,
  parameter int unsigned R_W = IR_W
) (
  input  logic [A_W-1:0] acc_i,
  input  logic           lm_i,
  output logic [R_W-1:0] ir_o,
  output logic           hit_o
);
  localparam logic signed [A_W-1:0] MAX_V = A_W'((64'd1 << (R_W-1)) - 64'd1);
  localparam logic signed [A_W-1:0] MIN_V = -MAX_V - A_W'(1);

  logic signed [A_W-1:0] acc_s, lo_s;

  always_comb begin
    acc_s = signed'(acc_i);
    lo_s  = lm_i ? '0 : MIN_V;
    hit_o = 1'b0;
    ir_o  = acc_i[R_W-1:0];
    if (acc_s > MAX_V) begin
      ir_o  = MAX_V[R_W-1:0];
      hit_o = 1'b1;
    end else if (acc_s < lo_s) begin
      ir_o  = lo_s[R_W-1:0];
      hit_o = 1'b1;
    end
  end
endmodule

// File: rtl/acc_ir_sat_flags.sv
module acc_ir_sat_flags
  import acc_ir_sat_pkg::*;
#(
  parameter int unsigned N = NUM_CH
) (
  input  logic [FLAG_W-1:0] flag_i,
  input  logic [N-1:0]      hit_i,
  output logic [FLAG_W-1:0] flag_o
);
  always_comb begin
    flag_o = flag_i;
    for (int unsigned k = 0; k < N; k++) begin
      if (hit_i[k]) flag_o = flag_o | ch_mask(k);
    end
  end
endmodule

// File: rtl/acc_ir_sat.sv
module acc_ir_sat
  import acc_ir_sat_pkg::*;
#(
  parameter bit UPDATE_FLAGS = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              lm_i,
  input  logic [ACC_W-1:0]  acc0_i,
  input  logic [ACC_W-1:0]  acc1_i,
  input  logic [ACC_W-1:0]  acc2_i,
  input  logic [FLAG_W-1:0] flag_i,
  output logic              valid_o,
  output logic [IR_W-1:0]   ir0_o,
  output logic [IR_W-1:0]   ir1_o,
  output logic [IR_W-1:0]   ir2_o,
  output logic [FLAG_W-1:0] flag_o
);
  logic [ACC_W-1:0]  acc_w [NUM_CH];
  logic [IR_W-1:0]   ir_w  [NUM_CH];
  logic [IR_W-1:0]   ir_q  [NUM_CH];
  logic [NUM_CH-1:0] hit_w;
  logic [FLAG_W-1:0] flag_w, flag_q;
  logic              valid_q;

  assign acc_w[0] = acc0_i;
  assign acc_w[1] = acc1_i;
  assign acc_w[2] = acc2_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    acc_ir_sat_lane #(.A_W(ACC_W), .R_W(IR_W)) lane_i (
      .acc_i (acc_w[g]),
      .lm_i  (lm_i),
      .ir_o  (ir_w[g]),
      .hit_o (hit_w[g])
    );
  end

  if (UPDATE_FLAGS) begin : g_flags
    acc_ir_sat_flags #(.N(NUM_CH)) flags_i (
      .flag_i (flag_i),
      .hit_i  (hit_w),
      .flag_o (flag_w)
    );
  end else begin : g_noflags
    assign flag_w = flag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      flag_q  <= '0;
      for (int k = 0; k < NUM_CH; k++) ir_q[k] <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        flag_q <= flag_w;
        for (int k = 0; k < NUM_CH; k++) ir_q[k] <= ir_w[k];
      end
    end
  end

  assign valid_o = valid_q;
  assign ir0_o   = ir_q[0];
  assign ir1_o   = ir_q[1];
  assign ir2_o   = ir_q[2];
  assign flag_o  = flag_q;
endmodule

// File: rtl/acc_ir_sat_chk.sv
module acc_ir_sat_chk
  import acc_ir_sat_pkg::*;
#(
  parameter bit UPDATE_FLAGS = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              lm_i,
  input logic [ACC_W-1:0]  acc0_i,
  input logic [ACC_W-1:0]  acc1_i,
  input logic [ACC_W-1:0]  acc2_i,
  input logic [FLAG_W-1:0] flag_i,
  input logic              valid_o,
  input logic [IR_W-1:0]   ir0_o,
  input logic [IR_W-1:0]   ir1_o,
  input logic [IR_W-1:0]   ir2_o,
  input logic [FLAG_W-1:0] flag_o
);
  logic in0;
  assign in0 = $signed(acc0_i) >= -32768 && $signed(acc0_i) <= 32767;

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R8
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R8
  AST_IR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(ir0_o) && $stable(ir1_o) && $stable(ir2_o) && $stable(flag_o))); // R9
  AST_NONNEG_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lm_i) |=> (!ir0_o[IR_W-1] && !ir1_o[IR_W-1] && !ir2_o[IR_W-1])); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !lm_i && in0) |=> (ir0_o == $past(acc0_i[IR_W-1:0]))); // R1

  if (UPDATE_FLAGS) begin : g_upd
    AST_FLAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> ((flag_o & $past(flag_i)) == $past(flag_i))); // R6
    AST_FLAG_SCOPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> ((flag_o & ~$past(flag_i) & 32'h7E3F_FFFF) == '0)); // R6
    AST_CH2_NO_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !flag_i[31] && !flag_i[24] && !flag_i[23])
        |=> (flag_o[31] == (flag_o[24] | flag_o[23]))); // R5
  end else begin : g_noupd
    AST_FLAG_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (flag_o == $past(flag_i))); // R11
  end
endmodule

bind acc_ir_sat acc_ir_sat_chk #(.UPDATE_FLAGS(UPDATE_FLAGS)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .lm_i(lm_i),
  .acc0_i(acc0_i), .acc1_i(acc1_i), .acc2_i(acc2_i), .flag_i(flag_i),
  .valid_o(valid_o), .ir0_o(ir0_o), .ir1_o(ir1_o), .ir2_o(ir2_o),
  .flag_o(flag_o)
);

// File: tb/acc_ir_sat_tb_top.sv
module acc_ir_sat_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        lm_i = 1'b0;
  logic [31:0] acc0_i = '0, acc1_i = '0, acc2_i = '0, flag_i = '0;
  logic        valid_o, nf_valid_o;
  logic [15:0] ir0_o, ir1_o, ir2_o, nf_ir0_o, nf_ir1_o, nf_ir2_o;
  logic [31:0] flag_o, nf_flag_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [15:0] exp_ir [3];
  logic [31:0] exp_flag = '0, exp_nf_flag = '0;
  logic        exp_valid = 1'b0;

  always #10 clk_i = ~clk_i;

  acc_ir_sat dut_i (
    .clk_i, .rst_ni, .valid_i, .lm_i, .acc0_i, .acc1_i, .acc2_i, .flag_i,
    .valid_o, .ir0_o, .ir1_o, .ir2_o, .flag_o
  );

  acc_ir_sat #(.UPDATE_FLAGS(1'b0)) dut_nf_i (
    .clk_i, .rst_ni, .valid_i, .lm_i, .acc0_i, .acc1_i, .acc2_i, .flag_i,
    .valid_o(nf_valid_o), .ir0_o(nf_ir0_o), .ir1_o(nf_ir1_o), .ir2_o(nf_ir2_o),
    .flag_o(nf_flag_o)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] clampv(int a, bit lm, output bit hit);
    int lo = lm ? 0 : -32768;
    hit = 1'b0;
    if (a > 32767) begin hit = 1'b1; return 16'(32767); end
    if (a < lo)    begin hit = 1'b1; return 16'(lo); end
    return 16'(a);
  endfunction

  task automatic compare(string tag);
    chk({tag, " ir0"}, ir0_o, exp_ir[0]);
    chk({tag, " ir1"}, ir1_o, exp_ir[1]);
    chk({tag, " ir2"}, ir2_o, exp_ir[2]);
    chk({tag, " flag"}, flag_o, exp_flag);
    chk("R8 valid", valid_o, exp_valid);
    chk("R11 nf_ir0", nf_ir0_o, exp_ir[0]);
    chk("R11 nf_ir2", nf_ir2_o, exp_ir[2]);
    chk("R11 nf_flag", nf_flag_o, exp_nf_flag);
  endtask

  task automatic cycle(string tag, bit v, bit lm, int a0, int a1, int a2, logic [31:0] f);
    bit h0, h1, h2;
    logic [15:0] r0, r1, r2;
    valid_i = v; lm_i = lm;
    acc0_i = a0; acc1_i = a1; acc2_i = a2; flag_i = f;
    r0 = clampv(a0, lm, h0);
    r1 = clampv(a1, lm, h1);
    r2 = clampv(a2, lm, h2);
    exp_valid = v;
    if (v) begin
      exp_ir[0] = r0; exp_ir[1] = r1; exp_ir[2] = r2;
      exp_nf_flag = f;
      exp_flag = f;
      if (h0) exp_flag |= 32'h8100_0000;
      if (h1) exp_flag |= 32'h8080_0000;
      if (h2) exp_flag |= 32'h0040_0000;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    exp_ir[0] = '0; exp_ir[1] = '0; exp_ir[2] = '0;
    acc0_i = 32'h7FFF_FFFF; flag_i = 32'hFFFF_FFFF; valid_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R10: reset state
    chk("R10 ir0", ir0_o, 0);
    chk("R10 flag", flag_o, 0);
    chk("R10 valid", valid_o, 0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    cycle("R1", 1, 0, 100, -200, 12345, 32'h0);
    cycle("R1", 1, 0, 40000, -40000, 0, 32'h0);
    cycle("R3", 1, 0, 32768, 0, 0, 32'h0);
    cycle("R3", 1, 0, -32769, 0, 0, 32'h0);
    cycle("R4", 1, 0, 0, 32768, 0, 32'h0);
    cycle("R4", 1, 1, 0, -1, 0, 32'h0);
    cycle("R5", 1, 0, 0, 0, 1 << 20, 32'h0);
    cycle("R5", 1, 1, 5, 6, -7, 32'h0);
    cycle("R7", 1, 0, 32767, -32768, 32767, 32'h0);
    cycle("R7", 1, 1, 0, 32767, 0, 32'h0);
    cycle("R2", 1, 1, -32768, -2147483647 - 1, 2147483647, 32'h0);
    cycle("R2", 1, 1, 1, 300, 32766, 32'h0);
    cycle("R6", 1, 0, 0, 0, 0, 32'h5A5A_1234);
    cycle("R6", 1, 0, 99999, 1, -99999, 32'h0003_0001);
    cycle("R6", 1, 1, -5, -5, -5, 32'hFFFF_FFFF);
    cycle("R9", 0, 1, 70000, -70000, 70000, 32'h1111_1111);
    cycle("R9", 0, 0, 1, 2, 3, 32'h0);
    cycle("R8", 1, 0, 7, 8, 9, 32'h0);

    for (int i = 0; i < 400; i++) begin
      int a[3];
      for (int k = 0; k < 3; k++) begin
        case ($urandom_range(0, 3))
          0: a[k] = int'($urandom);
          1: a[k] = $urandom_range(0, 65535) - 32768;
          2: a[k] = $urandom_range(0, 6) - 3 + (($urandom_range(0, 1) != 0) ? 32767 : -32768);
          default: a[k] = $urandom_range(0, 4) - 2;
        endcase
      end
      cycle(($urandom_range(0, 3) == 0) ? "R9" : "R1", $urandom_range(0, 3) != 0,
            $urandom_range(0, 1) != 0, a[0], a[1], a[2],
            ($urandom_range(0, 1) != 0) ? 32'($urandom) : 32'h0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule